// File: doc/BRIEF.md
# SPI Master Shift Engine with Slave-Ready Wait and Parity

This block is the serial engine of an SPI master for one data format. A transfer is requested on a valid/ready start channel that carries the word to send. The engine shifts a programmable number of bits MSB first on MOSI and collects the same number from MISO. The bit clock comes from a prescaler of the system clock. An extra parity bit can follow the data, and the parity bit sent back by the slave is checked against the received data.

A slave may have an active-low ready line (`ena_n`). When the wait option is on, the engine holds SCLK idle until that line is sampled low. A reload value bounds the wait. If the slave never answers, the transfer is dropped: the timeout flag is set, done pulses and no bit moves.

The start channel stalls through `start_ready`, which is high only while the engine is idle. A request is taken on a clock edge where `start_valid` and `start_ready` are both high. The result side has no back-pressure. `done` is a single-cycle pulse, and `rx_word`, `rx_err` and `timeout` keep their values until a later transfer changes them.

Top module: `spi_ena_master`

## Requirements
- R1: `start_ready` is high exactly while no transfer or wait is in progress. On the accepting edge the engine captures `tx_word` and all `cfg_*` inputs. Changes to these inputs afterwards have no effect on that transfer.
- R2: SCLK rests low. While shifting, its period is 2×(`cfg_prescale`+1) system clocks. A transfer makes exactly one rising SCLK edge per transmitted bit.
- R3: Bits go out MSB first. MOSI changes only when SCLK falls (or when shifting begins), and MISO is sampled when SCLK rises.
- R4: `cfg_len` (1 to DATA_W) sets the character length. Transmit bits at or above that length are ignored. `rx_word` is right-aligned, with zeros above the received bits.
- R5: With `cfg_wait_ena`=0 the engine ignores `ena_n`. The first SCLK rise comes `cfg_prescale`+1 cycles after the accepting edge.
- R6: With `cfg_wait_ena`=1 there is no SCLK edge while `ena_n` is high. If `ena_n` is already low, the first rise comes `cfg_prescale`+2 cycles after acceptance.
- R7: With `cfg_wait_ena`=1, if `ena_n` stays high for `cfg_timeout`+1 consecutive samples, the following happens. `timeout` is set and `done` pulses `cfg_timeout`+1 cycles after acceptance. There is no SCLK edge, and `rx_word` keeps its old value.
- R8: With `cfg_parity_en`=1, one parity bit follows the last data bit on MOSI. For `cfg_parity_odd`=0 it is the XOR of the sent data bits (even parity). For `cfg_parity_odd`=1 it is the inverse of that XOR.
- R9: `rx_err` is set with `done` when parity is enabled and the received parity bit differs from the parity of the received data (same polarity rule as R8). It is never set with parity disabled, and it is cleared only by the next accepted start.
- R10: `done` is high for exactly one cycle per accepted request. `rx_word` is valid from that cycle onward.
- R11: `timeout` stays set after a timed-out request and is cleared on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len | input | LEN_W (5) | Character length in bits, 1 to DATA_W |
| cfg_prescale | input | PRE_W (8) | SCLK half period minus one, in system clocks |
| cfg_parity_en | input | 1 | 1 = append and check a parity bit |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_wait_ena | input | 1 | 1 = wait for `ena_n` low before shifting |
| cfg_timeout | input | TO_W (8) | Wait bound: timeout after this value + 1 high samples |
| start_valid | input | 1 | Transfer request |
| start_ready | output | 1 | Engine idle, request can be taken |
| tx_word | input | DATA_W (16) | Word to send, right-aligned |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ena_n | input | 1 | Slave ready, active low |
| rx_word | output | DATA_W (16) | Received word, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| rx_err | output | 1 | Received parity mismatch |
| timeout | output | 1 | Slave-ready wait expired |

## Verification
The bench aims at the ends of the length range and at the places where the bit counter and the parity slot meet. These cases are a 1-bit character, a full 16-bit word, and a short length whose upper transmit bits are garbage. An off-by-one there would add or drop a rising edge or leak upper bits into the output. The slave model returns a deliberately wrong parity bit, so a checker that compared the wrong polarity, or never latched the bit, shows up as a missing or spurious `rx_err`. The wait path is exercised with ENA already low, with ENA going low late, and with ENA never low at reload values 5 and 0. A wrong timeout count moves the done cycle, and an engine that leaked through the wait would toggle SCLK early.

// File: rtl/spi_ena_pkg.sv
package spi_ena_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_ena_parity.sv
module spi_ena_parity #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic [DATA_W-1:0] data,
  input  logic [LEN_W-1:0]  len,
  input  logic              odd,
  output logic              par
);
  // XOR over the low len bits only; odd polarity seeds with 1
  always_comb begin
    par = odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(len)) par = par ^ data[i];
    end
  end
endmodule

// File: rtl/spi_ena_clkdiv.sv
module spi_ena_clkdiv #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (!run || cnt_q == limit) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == limit);

  // R2: the half-period counter never passes its limit while running
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/spi_ena_waiter.sv
module spi_ena_waiter #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TO_W-1:0] reload,
  input  logic            active,
  input  logic            ena_n,
  output logic            go,
  output logic            expire
);
  logic [TO_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      left_q <= '0;
    else if (load)                   left_q <= reload;
    else if (active && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign go     = active && !ena_n;
  assign expire = active && ena_n && (left_q == '0);

  // R7: the budget only shrinks while waiting
  p_budget_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && !$past(load)) |-> (left_q <= $past(left_q)));
endmodule

// File: rtl/spi_ena_master.sv
module spi_ena_master
  import spi_ena_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5,
  parameter int PRE_W  = 8,
  parameter int TO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [PRE_W-1:0]  cfg_prescale,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_wait_ena,
  input  logic [TO_W-1:0]   cfg_timeout,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [DATA_W-1:0] tx_word,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  input  logic              ena_n,
  output logic [DATA_W-1:0] rx_word,
  output logic              done,
  output logic              rx_err,
  output logic              timeout
);
  localparam int CW = LEN_W + 1;

  function automatic logic pick_bit(input logic [DATA_W-1:0] v, input int pos);
    logic b;
    b = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i == pos) b = v[i];
    end
    return b;
  endfunction

  eng_state_e        state_q;
  logic [LEN_W-1:0]  len_q, bcnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic              par_en_q, odd_q, par_rx_q;
  logic [DATA_W-1:0] tx_q, rx_sh_q, rx_word_q;
  logic              sclk_q, mosi_q, done_q, rx_err_q, to_q;

  logic              accept, tick, w_go, w_exp, tx_par, rx_par_exp;
  logic [CW-1:0]     nbits;
  logic              last_bit, more_data, in_data;

  assign start_ready = (state_q == ST_IDLE);
  assign accept      = start_valid && start_ready;
  assign nbits       = {1'b0, len_q} + CW'(par_en_q);
  assign last_bit    = ({1'b0, bcnt_q} == nbits - 1'b1);
  assign more_data   = (({1'b0, bcnt_q} + 1'b1) < {1'b0, len_q});
  assign in_data     = (bcnt_q < len_q);

  spi_ena_waiter #(.TO_W(TO_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(accept), .reload(cfg_timeout),
    .active(state_q == ST_WAIT), .ena_n(ena_n), .go(w_go), .expire(w_exp)
  );

  spi_ena_clkdiv #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_SHIFT), .limit(pre_q), .tick(tick)
  );

  spi_ena_parity #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_txpar (
    .data(tx_q), .len(len_q), .odd(odd_q), .par(tx_par)
  );

  spi_ena_parity #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rxpar (
    .data(rx_sh_q), .len(len_q), .odd(odd_q), .par(rx_par_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      len_q     <= '0;
      bcnt_q    <= '0;
      pre_q     <= '0;
      par_en_q  <= 1'b0;
      odd_q     <= 1'b0;
      par_rx_q  <= 1'b0;
      tx_q      <= '0;
      rx_sh_q   <= '0;
      rx_word_q <= '0;
      sclk_q    <= 1'b0;
      mosi_q    <= 1'b0;
      done_q    <= 1'b0;
      rx_err_q  <= 1'b0;
      to_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            len_q    <= cfg_len;
            pre_q    <= cfg_prescale;
            par_en_q <= cfg_parity_en;
            odd_q    <= cfg_parity_odd;
            tx_q     <= tx_word;
            bcnt_q   <= '0;
            rx_sh_q  <= '0;
            par_rx_q <= 1'b0;
            sclk_q   <= 1'b0;
            rx_err_q <= 1'b0;
            to_q     <= 1'b0;
            if (cfg_wait_ena) begin
              state_q <= ST_WAIT;
            end else begin
              state_q <= ST_SHIFT;
              mosi_q  <= pick_bit(tx_word, int'(cfg_len) - 1);
            end
          end
        end
        ST_WAIT: begin
          if (w_go) begin
            state_q <= ST_SHIFT;
            mosi_q  <= pick_bit(tx_q, int'(len_q) - 1);
          end else if (w_exp) begin
            to_q    <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              if (in_data) rx_sh_q  <= {rx_sh_q[DATA_W-2:0], miso};
              else         par_rx_q <= miso;
            end else begin
              sclk_q <= 1'b0;
              if (last_bit) begin
                done_q    <= 1'b1;
                rx_word_q <= rx_sh_q;
                rx_err_q  <= par_en_q && (par_rx_q != rx_par_exp);
                mosi_q    <= 1'b0;
                state_q   <= ST_IDLE;
              end else begin
                bcnt_q <= bcnt_q + 1'b1;
                mosi_q <= more_data ? pick_bit(tx_q, int'(len_q) - 2 - int'(bcnt_q))
                                    : tx_par;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign rx_word = rx_word_q;
  assign done    = done_q;
  assign rx_err  = rx_err_q;
  assign timeout = to_q;

  // R2: SCLK rests low outside the shift phase
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_SHIFT) |-> !sclk_q);

  // R3: MOSI holds while SCLK is high
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT && sclk_q) |-> $stable(mosi_q));

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7: an expired wait ends in idle with the flag set
  p_expire_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_exp |=> (state_q == ST_IDLE && to_q && done_q));

  // R9: a parity error can only appear with parity enabled
  p_err_needs_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_err_q) |-> (par_en_q && done_q));

  // R11: timed-out requests never carry a parity error
  p_timeout_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
    to_q |-> !rx_err_q);
endmodule

// File: tb/spi_ena_master_tb_top.sv
module spi_ena_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cfg_len = 5'd8;
  logic [7:0]  cfg_prescale = 8'd0;
  logic        cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0, cfg_wait_ena = 1'b0;
  logic [7:0]  cfg_timeout = 8'd0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [15:0] tx_word = 16'h0;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic        ena_n = 1'b1;
  logic [15:0] rx_word;
  logic        done, rx_err, timeout;

  always #10 clk = ~clk;

  spi_ena_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_prescale(cfg_prescale),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_wait_ena(cfg_wait_ena), .cfg_timeout(cfg_timeout),
    .start_valid(start_valid), .start_ready(start_ready), .tx_word(tx_word),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ena_n(ena_n),
    .rx_word(rx_word), .done(done), .rx_err(rx_err), .timeout(timeout)
  );

  typedef struct {
    logic [15:0] rx;
    logic [31:0] mbits;
    int          nbits;
    bit          err;
    bit          to;
    int          lat;
    int          acc;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0, n_fail = 0, cyc = 0;
  int          rises = 0, first_cyc = 0, last_rise = 0, cur_period = 2, sidx = 0;
  bit          period_bad = 0, sclk_d = 0;
  logic [31:0] mcap = 0, slave_vec = 0;
  logic [15:0] last_rx = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: slave model plus scoreboard
  always @(negedge clk) begin
    if (sclk && !sclk_d) begin
      rises++;
      mcap = {mcap[30:0], mosi};
      if (rises == 1) first_cyc = cyc;
      else if (cyc - last_rise != cur_period) period_bad = 1;
      last_rise = cyc;
    end
    if (!sclk && sclk_d) begin
      sidx++;
      miso = slave_vec[31 - sidx];
    end
    sclk_d = sclk;
    if (done) begin
      if (sb_q.size() == 0) begin
        chk(0, "R10", "done without request", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rx_word == e.rx, "R4", "rx_word", rx_word, e.rx);
        chk(rx_err == e.err, "R9", "rx_err", rx_err, e.err);
        chk(timeout == e.to, "R7", "timeout flag", timeout, e.to);
        chk(rises == e.nbits, "R2", "SCLK rise count", rises, e.nbits);
        chk(mcap == e.mbits, "R3/R8", "MOSI bit stream", mcap, e.mbits);
        chk(!period_bad, "R2", "SCLK period", 0, cur_period);
        if (e.to)
          chk(cyc - e.acc == e.lat, "R7", "timeout latency", cyc - e.acc, e.lat);
        else if (e.lat >= 0)
          chk(first_cyc - e.acc == e.lat, "R5/R6", "first SCLK rise latency",
              first_cyc - e.acc, e.lat);
      end
      rises = 0; mcap = 0; period_bad = 0;
    end
  end

  // driver: ena_delay -1 keeps ENA high, 0 low at start, k low after k cycles
  task automatic run_xfer(input int len, input logic [15:0] tx, input logic [15:0] sd,
                          input int pre, input bit pen, input bit odd, input bit bad_par,
                          input bit wen, input int tmo, input int ena_delay);
    logic [15:0] mask, txm, sdm;
    logic        tpar, spar;
    bit          tmo_case;
    exp_t        e;
    mask     = (len == 16) ? 16'hFFFF : ((16'd1 << len) - 16'd1);
    txm      = tx & mask;
    sdm      = sd & mask;
    tpar     = (^txm) ^ odd;
    spar     = (^sdm) ^ odd ^ bad_par;
    tmo_case = wen && (ena_delay < 0);
    e.mbits  = tmo_case ? 32'd0 : (pen ? ((32'(txm) << 1) | 32'(tpar)) : 32'(txm));
    e.nbits  = tmo_case ? 0 : len + int'(pen);
    e.rx     = tmo_case ? last_rx : sdm;
    last_rx  = e.rx;
    e.err    = !tmo_case && pen && bad_par;
    e.to     = tmo_case;
    e.lat    = tmo_case ? tmo + 1 : (wen ? ((ena_delay == 0) ? pre + 2 : -1) : pre + 1);
    slave_vec = (32'(sdm) << (32 - len)) | (32'(spar & pen) << (31 - len));

    @(negedge clk);
    while (!start_ready) @(negedge clk);
    cfg_len = 5'(len); cfg_prescale = 8'(pre); cfg_parity_en = pen;
    cfg_parity_odd = odd; cfg_wait_ena = wen; cfg_timeout = 8'(tmo);
    tx_word = tx;
    ena_n = (ena_delay == 0) ? 1'b0 : 1'b1;
    sidx = 0;
    miso = slave_vec[31];
    cur_period = 2 * (pre + 1);
    start_valid = 1'b1;
    @(posedge clk);
    #1;
    e.acc = cyc;
    sb_q.push_back(e);
    start_valid = 1'b0;
    // R1: captured values must survive input changes
    tx_word = ~tx; cfg_len = 5'd3; cfg_parity_odd = ~odd; cfg_prescale = 8'd7;
    @(negedge clk);
    chk(!start_ready, "R1", "ready low while busy", start_ready, 0);
    chk(!timeout && !rx_err, "R11", "flags cleared on accept", {timeout, rx_err}, 0);
    if (ena_delay > 0) begin
      repeat (ena_delay) @(negedge clk);
      chk(rises == 0, "R6", "no SCLK while ENA high", rises, 0);
      ena_n = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    ena_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sclk && !done && !timeout && !rx_err, "R2", "reset outputs",
        {sclk, done, timeout, rx_err}, 0);
    chk(start_ready, "R1", "ready after reset", start_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_xfer(8,  16'h00A5, 16'h003C, 1, 0, 0, 0, 0, 0, -1);  // R2 R3 R5
    run_xfer(16, 16'hBEEF, 16'h1234, 0, 0, 0, 0, 0, 0, -1);  // R4 full width
    run_xfer(1,  16'h0001, 16'h0001, 2, 0, 0, 0, 0, 0, -1);  // R4 single bit
    run_xfer(5,  16'hFFE6, 16'hFFEB, 3, 0, 0, 0, 0, 0, -1);  // R4 upper bits ignored
    run_xfer(8,  16'h0096, 16'h005A, 1, 1, 0, 0, 0, 0, -1);  // R8 even parity
    run_xfer(7,  16'h0055, 16'h0033, 0, 1, 1, 1, 0, 0, -1);  // R9 bad odd parity
    repeat (5) @(negedge clk);
    chk(rx_err, "R9", "rx_err held", rx_err, 1);
    run_xfer(12, 16'h0ABC, 16'h0123, 1, 1, 1, 0, 0, 0, -1);  // R8 odd, R9 cleared
    run_xfer(8,  16'h00C3, 16'h0081, 2, 0, 0, 0, 1, 20, 0);  // R6 ENA already low
    run_xfer(8,  16'h0017, 16'h00E4, 0, 1, 0, 0, 1, 20, 6);  // R6 ENA late
    run_xfer(8,  16'h00FF, 16'h00FF, 1, 0, 0, 0, 1, 5, -1);  // R7 timeout
    repeat (5) @(negedge clk);
    chk(timeout, "R11", "timeout held", timeout, 1);
    chk(!sclk, "R7", "SCLK idle after timeout", sclk, 0);
    run_xfer(6,  16'h002D, 16'h0011, 0, 0, 0, 0, 0, 0, -1);  // R5 ENA high ignored
    run_xfer(4,  16'h0009, 16'h0006, 0, 0, 0, 0, 1, 0, -1);  // R7 zero reload

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R10", "all requests completed", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule